// File: doc/BRIEF.md
# Compressed-Tile Header Payload Packer

This block reads a stream of 128-bit header blocks from a compressed framebuffer, one for each superblock. From each header it works out how many payload bytes that superblock needs, and it places the payloads one after another in a packed body layout. For every header it emits a (size, offset) pair. When the header marked as the last one of a frame has been emitted, the block reports the total body size of that frame.

Each header holds sixteen 6-bit subblock size codes. Most codes count bytes directly. Code 1 stands for a subblock that is stored raw, and it counts as the configured uncompressed size. When solid-colour detection is enabled, a zero code in subblock 0 marks a payload-free block. The summed size is rounded up to a multiple of 16 bytes. Offsets then add up in the order the headers arrive.

The block has one register stage. Both ends use a valid/ready handshake. Back-pressure on the pair output stops the block from accepting headers.

Top module: `hdr_payload_packer`

## Requirements
- R1: The 128-bit header is read as a 64-bit low word (bits 63:0) and a 64-bit high word (bits 127:64). Subblock i's code is the 6-bit field that starts at bit 32+6*i of the whole 128-bit vector. So subblock 5 takes its low 2 bits from low-word bits 63:62 and its high 4 bits from high-word bits 3:0. Bits 31:0 do not affect the size.
- R2: A code of 1 adds `uncomp_bytes_i` bytes to the sum, not 1.
- R3: Any other code c adds c bytes. The reported size is the sum rounded up to the next multiple of 16.
- R4: When `solid_en_i` is 1 and subblock 0's code is 0, the size is 0 and every other field is ignored. When `solid_en_i` is 0, the normal sum is used.
- R5: The first payload of a frame has offset 0. Each later offset is the previous offset plus the previous size, so a zero-size payload does not move the offset. Offsets are 32 bits wide.
- R6: `body_done_o` pulses for one cycle, one cycle after the pair of a header accepted with `hdr_last_i`=1 is taken by the consumer. At that time `body_size_o` gives the frame total (final offset plus final size). The next header starts a new frame at offset 0.
- R7: While `pair_valid_o` is 1 and `pair_ready_i` is 0, the pair holds steady and `hdr_ready_o` is 0. Whenever the output register is empty, or is being drained in the same cycle, `hdr_ready_o` is 1. No pair is lost or repeated.
- R8: Immediately after reset, `pair_valid_o` and `body_done_o` are 0 and `hdr_ready_o` is 1.
- R9: The pair for a header accepted on a clock edge appears on `pair_valid_o` / `pair_size_o` / `pair_offset_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header present |
| hdr_ready_o | output | 1 | Header accepted when both are high |
| hdr_data_i | input | 128 | Header block |
| hdr_last_i | input | 1 | Header is the final one of its frame |
| uncomp_bytes_i | input | 16 | Byte count for a raw subblock (code 1), a multiple of 16 |
| solid_en_i | input | 1 | Enables solid-colour detection |
| pair_valid_o | output | 1 | Pair present |
| pair_ready_i | input | 1 | Consumer takes the pair |
| pair_size_o | output | 32 | Payload size in bytes |
| pair_offset_o | output | 32 | Payload offset in the body |
| body_size_o | output | 32 | Frame body total, valid with done |
| body_done_o | output | 1 | One-cycle pulse marking the frame total |

## Verification
The assertions assume that reset is applied before the first handshake. They also assume that `pair_ready_i` and `hdr_valid_i` are always known, so that the hold and ready properties evaluate on real values. They do not assume that headers stay stable while waiting, because acceptance is gated only by `hdr_ready_o`. The stimulus keeps `uncomp_bytes_i` at multiples of 16 between 16 and 64. It changes headers, the last flag and the consumer ready freely from cycle to cycle. It also switches solid detection both within a frame and between frames, so the stall, drain-and-refill and back-to-back-frame paths are all exercised.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam int HDR_W      = 128;
  localparam int N_SUB      = 16;
  localparam int CODE_W     = 6;
  localparam int FIELD_BASE = 32;
  localparam int RAW_CODE   = 1;
endpackage

// File: rtl/hpp_field_extract.sv
module hpp_field_extract
  import hpp_pkg::*;
(
  input  logic [HDR_W-1:0]              hdr_i,
  output logic [N_SUB-1:0][CODE_W-1:0]  codes_o
);
  // fields run contiguously across the word boundary (subblock 5 straddles)
  for (genvar i = 0; i < N_SUB; i++) begin : g_fld
    assign codes_o[i] = hdr_i[FIELD_BASE + CODE_W*i +: CODE_W];
  end
endmodule

// File: rtl/hpp_size_calc.sv
module hpp_size_calc
  import hpp_pkg::*;
#(
  parameter int UNC_W      = 16,
  parameter int OUT_W      = 32,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic [N_SUB-1:0][CODE_W-1:0] codes_i,
  input  logic [UNC_W-1:0]             uncomp_i,
  input  logic                         solid_en_i,
  output logic [OUT_W-1:0]             size_o
);
  localparam int SUM_W = UNC_W + $clog2(N_SUB) + 1;
  localparam logic [SUM_W-1:0] AMASK = SUM_W'((1 << ALIGN_LOG2) - 1);

  logic [N_SUB-1:0][UNC_W-1:0] term;
  logic [SUM_W-1:0]            acc, rounded;
  logic                        solid;

  for (genvar i = 0; i < N_SUB; i++) begin : g_term
    assign term[i] = (codes_i[i] == CODE_W'(RAW_CODE)) ? uncomp_i
                   : {{(UNC_W-CODE_W){1'b0}}, codes_i[i]};
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_SUB; i++) acc = acc + SUM_W'(term[i]);
  end

  assign rounded = (acc + AMASK) & ~AMASK;
  assign solid   = solid_en_i && (codes_i[0] == '0);
  assign size_o  = solid ? '0 : OUT_W'(rounded);
endmodule

// File: rtl/hpp_layout_stage.sv
module hpp_layout_stage #(
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [OUT_W-1:0] in_size_i,
  input  logic             in_last_i,
  output logic             pair_valid_o,
  input  logic             pair_ready_i,
  output logic [OUT_W-1:0] pair_size_o,
  output logic [OUT_W-1:0] pair_offset_o,
  output logic [OUT_W-1:0] body_size_o,
  output logic             body_done_o
);
  logic             valid_q, last_q, done_q;
  logic [OUT_W-1:0] size_q, off_q, run_q, body_q;
  logic             acc, emit;

  assign in_ready_o = !valid_q || pair_ready_i;
  assign acc        = in_valid_i && in_ready_o;
  assign emit       = valid_q && pair_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      size_q  <= '0;
      off_q   <= '0;
      run_q   <= '0;
    end else begin
      if (acc) begin
        valid_q <= 1'b1;
        last_q  <= in_last_i;
        size_q  <= in_size_i;
        off_q   <= run_q;
        run_q   <= in_last_i ? '0 : run_q + in_size_i;
      end else if (emit) begin
        valid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      body_q <= '0;
    end else begin
      done_q <= emit && last_q;
      if (emit && last_q) body_q <= off_q + size_q;
    end
  end

  assign pair_valid_o  = valid_q;
  assign pair_size_o   = size_q;
  assign pair_offset_o = off_q;
  assign body_size_o   = body_q;
  assign body_done_o   = done_q;
endmodule

// File: rtl/hdr_payload_packer.sv
module hdr_payload_packer
  import hpp_pkg::*;
#(
  parameter int UNC_W      = 16,
  parameter int OUT_W      = 32,
  parameter int ALIGN_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  output logic             hdr_ready_o,
  input  logic [HDR_W-1:0] hdr_data_i,
  input  logic             hdr_last_i,
  input  logic [UNC_W-1:0] uncomp_bytes_i,
  input  logic             solid_en_i,
  output logic             pair_valid_o,
  input  logic             pair_ready_i,
  output logic [OUT_W-1:0] pair_size_o,
  output logic [OUT_W-1:0] pair_offset_o,
  output logic [OUT_W-1:0] body_size_o,
  output logic             body_done_o
);
  logic [N_SUB-1:0][CODE_W-1:0] codes;
  logic [OUT_W-1:0]             size;

  hpp_field_extract u_fld (
    .hdr_i   (hdr_data_i),
    .codes_o (codes)
  );

  hpp_size_calc #(.UNC_W(UNC_W), .OUT_W(OUT_W), .ALIGN_LOG2(ALIGN_LOG2)) u_size (
    .codes_i    (codes),
    .uncomp_i   (uncomp_bytes_i),
    .solid_en_i (solid_en_i),
    .size_o     (size)
  );

  hpp_layout_stage #(.OUT_W(OUT_W)) u_lay (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_valid_i    (hdr_valid_i),
    .in_ready_o    (hdr_ready_o),
    .in_size_i     (size),
    .in_last_i     (hdr_last_i),
    .pair_valid_o  (pair_valid_o),
    .pair_ready_i  (pair_ready_i),
    .pair_size_o   (pair_size_o),
    .pair_offset_o (pair_offset_o),
    .body_size_o   (body_size_o),
    .body_done_o   (body_done_o)
  );
endmodule

// File: rtl/hpp_checker.sv
module hpp_checker #(
  parameter int OUT_W      = 32,
  parameter int ALIGN_LOG2 = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hdr_valid_i,
  input logic             hdr_ready_o,
  input logic             pair_valid_o,
  input logic             pair_ready_i,
  input logic [OUT_W-1:0] pair_size_o,
  input logic [OUT_W-1:0] pair_offset_o,
  input logic [OUT_W-1:0] body_size_o,
  input logic             body_done_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (pair_valid_o && pair_ready_i) seen_q <= 1'b1;
  end

  AST_SIZE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (pair_size_o[ALIGN_LOG2-1:0] == '0)); // R3

  AST_PAIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && !pair_ready_i) |=>
      (pair_valid_o && $stable(pair_size_o) && $stable(pair_offset_o))); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && !pair_ready_i) |-> !hdr_ready_o); // R7

  AST_EMPTY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_o |-> hdr_ready_o); // R8

  AST_FIRST_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && !seen_q) |-> (pair_offset_o == '0)); // R5

  AST_DONE_FOLLOWS_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && pair_ready_i) |=>
      (!body_done_o || body_size_o == $past(pair_offset_o + pair_size_o))); // R6

  AST_DONE_NEEDS_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(body_done_o) |-> $past(pair_valid_o && pair_ready_i)); // R6
endmodule

bind hdr_payload_packer hpp_checker #(.OUT_W(OUT_W), .ALIGN_LOG2(ALIGN_LOG2)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hdr_valid_i   (hdr_valid_i),
  .hdr_ready_o   (hdr_ready_o),
  .pair_valid_o  (pair_valid_o),
  .pair_ready_i  (pair_ready_i),
  .pair_size_o   (pair_size_o),
  .pair_offset_o (pair_offset_o),
  .body_size_o   (body_size_o),
  .body_done_o   (body_done_o)
);

// File: tb/tb_hdr_payload_packer.sv
`timescale 1ns/1ps
module tb_hdr_payload_packer;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         hdr_valid_i = 1'b0;
  logic         hdr_ready_o;
  logic [127:0] hdr_data_i = '0;
  logic         hdr_last_i = 1'b0;
  logic [15:0]  uncomp_bytes_i = 16'd64;
  logic         solid_en_i = 1'b0;
  logic         pair_valid_o;
  logic         pair_ready_i = 1'b0;
  logic [31:0]  pair_size_o, pair_offset_o, body_size_o;
  logic         body_done_o;

  always #2.5 clk_i = ~clk_i;

  hdr_payload_packer dut (.*);

  typedef struct {
    longint unsigned size;
    longint unsigned off;
    bit              last;
    string           tag;
  } ent_t;

  ent_t            q[$];
  longint unsigned run_off = 0;
  bit              exp_done = 0;
  longint unsigned exp_body = 0;
  int              total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned ref_size(input logic [127:0] h,
                                               input int unsigned unc, input bit sol);
    longint unsigned s = 0;
    if (sol && h[32 +: 6] == 6'd0) return 0;
    for (int i = 0; i < 16; i++) begin
      int unsigned c = h[32 + 6*i +: 6];
      s += (c == 1) ? unc : c;
    end
    return ((s + 15) / 16) * 16;
  endfunction

  function automatic logic [127:0] mk_hdr(input logic [15:0][5:0] c, input logic [31:0] lo);
    logic [127:0] h = '0;
    h[31:0] = lo;
    for (int i = 0; i < 16; i++) h[32 + 6*i +: 6] = c[i];
    return h;
  endfunction

  task automatic check_outputs();
    chk(pair_valid_o === (q.size() > 0), "R9", "pair_valid", pair_valid_o, q.size() > 0);
    if (q.size() > 0 && pair_valid_o === 1'b1) begin
      chk(pair_size_o == q[0].size, q[0].tag, "pair_size", pair_size_o, q[0].size);
      chk(pair_offset_o == q[0].off, "R5", "pair_offset", pair_offset_o, q[0].off);
    end
    chk(body_done_o === exp_done, "R6", "body_done", body_done_o, exp_done);
    if (exp_done) chk(body_size_o == exp_body, "R6", "body_size", body_size_o, exp_body);
  endtask

  task automatic step(input bit v, input logic [127:0] d, input bit l, input bit r,
                      input bit sol, input logic [15:0] unc, input string tag,
                      output bit accepted);
    bit mready, emit, acc, nd;
    longint unsigned nbody, sz;
    @(negedge clk_i);
    check_outputs();
    hdr_valid_i = v; hdr_data_i = d; hdr_last_i = l; pair_ready_i = r;
    solid_en_i = sol; uncomp_bytes_i = unc;
    #1;
    mready = (q.size() == 0) || r;
    chk(hdr_ready_o === mready, "R7", "hdr_ready", hdr_ready_o, mready);
    emit = (q.size() > 0) && r;
    acc  = v && mready;
    nd = 0; nbody = exp_body;
    if (emit) begin
      nd = q[0].last;
      nbody = q[0].off + q[0].size;
      void'(q.pop_front());
    end
    if (acc) begin
      ent_t e;
      sz = ref_size(d, unc, sol);
      e.size = sz; e.off = run_off; e.last = l; e.tag = tag;
      q.push_back(e);
      run_off = l ? 0 : (run_off + sz) & 64'hFFFF_FFFF;
    end
    exp_done = nd;
    exp_body = nbody;
    accepted = acc;
  endtask

  task automatic send(input logic [127:0] d, input bit l, input bit sol,
                      input logic [15:0] unc, input string tag);
    bit a = 0;
    while (!a) step(1'b1, d, l, 1'b1, sol, unc, tag, a);
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b1, 1'b0, 16'd64, "R9", a);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [15:0][5:0] c;
    bit a;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    chk(pair_valid_o === 1'b0, "R8", "pair_valid in reset", pair_valid_o, 0);
    chk(body_done_o === 1'b0, "R8", "body_done in reset", body_done_o, 0);
    chk(hdr_ready_o === 1'b1, "R8", "hdr_ready in reset", hdr_ready_o, 1);
    rst_ni = 1'b1;

    // R3: all-zero codes, solid off -> 0; all code 63 -> 1008
    for (int i = 0; i < 16; i++) c[i] = 6'd0;
    send(mk_hdr(c, 32'hFFFF_FFFF), 0, 0, 16'd64, "R3");
    for (int i = 0; i < 16; i++) c[i] = 6'd63;
    send(mk_hdr(c, 32'h0), 0, 0, 16'd64, "R3");
    // R1: single nonzero field at each position (includes straddling subblock 5)
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 16; i++) c[i] = 6'd0;
      c[p] = 6'(17 + p);
      send(mk_hdr(c, 32'hA5A5_5A5A), 0, 0, 16'd64, "R1");
    end
    // R2: raw subblocks
    for (int i = 0; i < 16; i++) c[i] = (i % 3 == 0) ? 6'd1 : 6'd5;
    send(mk_hdr(c, 32'h0), 0, 0, 16'd48, "R2");
    for (int i = 0; i < 16; i++) c[i] = 6'd1;
    send(mk_hdr(c, 32'h0), 0, 1, 16'd16, "R2");
    // R4: solid detection on vs off with same header
    for (int i = 0; i < 16; i++) c[i] = (i == 0) ? 6'd0 : 6'd9;
    send(mk_hdr(c, 32'h0), 0, 1, 16'd64, "R4");
    send(mk_hdr(c, 32'h0), 0, 0, 16'd64, "R4");
    // R5: zero-size payload does not advance offset
    for (int i = 0; i < 16; i++) c[i] = 6'd0;
    send(mk_hdr(c, 32'h0), 0, 1, 16'd64, "R5");
    for (int i = 0; i < 16; i++) c[i] = 6'd2;
    send(mk_hdr(c, 32'h0), 1, 0, 16'd64, "R6");
    // R6: back-to-back single-header frames
    send(mk_hdr(c, 32'h0), 1, 0, 16'd64, "R6");
    send(mk_hdr(c, 32'h0), 1, 0, 16'd32, "R6");
    idle(4);

    // R7: random valid/ready with back-pressure
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] u;
      for (int i = 0; i < 16; i++) begin
        int k = $urandom_range(0, 5);
        c[i] = (k == 0) ? 6'd0 : (k == 1) ? 6'd1 : 6'($urandom);
      end
      u = 16'(16 * $urandom_range(1, 4));
      step($urandom_range(0, 3) != 0, mk_hdr(c, $urandom), $urandom_range(0, 4) == 0,
           $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, u, "R7", a);
    end
    idle(6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule